// File: doc/BRIEF.md
# Rotate Unit with Carry and Overflow Flags

This block rotates an operand of 8, 16, 32 or 64 bits in a single clock. It offers plain rotates in both directions and rotates in both directions that pass through the carry flag. It takes the incoming carry and overflow flags and returns their updated values beside the rotated result. The full rotation comes from a single shift of a doubled operand. There is no bit-serial loop, so any count finishes in the same cycle.

A caller presents the operation, the size, the operand, a raw 8-bit count and the two flags, and raises `in_valid` for one cycle. One clock later the registered result, the flags and a one-cycle `out_valid` pulse appear. The outputs keep their last values until the next strobe. The raw count is first masked according to the size. The masked count is then reduced to an effective rotate distance. Both of these values control when the flags are updated.

Top module: `rot_carry_unit`

## Requirements
- R1: The raw count is masked to its low 6 bits for 64-bit operands and to its low 5 bits for the other sizes. A raw count whose masked value is zero leaves the result, carry and overflow equal to their inputs.
- R2: Plain rotates (op 0 = left, op 1 = right) move the operand by the masked count modulo the width. Size encoding: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits.
- R3: Rotate left through carry (op 2) with effective count n rotates the (w+1)-bit value {carry, operand} left by n. The new carry is operand bit w−n, and a zero n changes nothing.
- R4: Rotate right through carry (op 3) with effective count n rotates {carry, operand} right by n. The new carry is operand bit n−1, and a zero n changes nothing.
- R5: For the carry rotates, the masked count is reduced modulo 9 for bytes and modulo 17 for 16-bit words. It is used unreduced for 32 and 64 bits.
- R6: When the masked count is nonzero, plain rotate left sets carry to result bit 0 and plain rotate right sets carry to the result MSB. This holds even when the effective distance is zero.
- R7: When the masked count is exactly 1, overflow is computed per operation. Rotate left and left-through-carry give result MSB XOR new carry. Plain rotate right gives result MSB XOR result bit w−2. Right-through-carry gives original operand MSB XOR incoming carry.
- R8: When the masked count is not 1, overflow passes through unchanged. A carry rotate with zero effective count keeps the incoming carry.
- R9: Operand bits above the selected width are ignored, and the result is zero above the selected width.
- R10: Outputs load only in the clock after `in_valid`, and `out_valid` is high for exactly that cycle. Otherwise the outputs hold. Synchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 0 rotl, 1 rotr, 2 rotl through carry, 3 rotr through carry |
| size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| operand | input | 64 | Value to rotate (upper bits beyond size ignored) |
| count | input | 8 | Raw rotate count |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| result | output | 64 | Rotated value, zero-extended |
| cf_out | output | 1 | Updated carry flag |
| of_out | output | 1 | Updated overflow flag |
| out_valid | output | 1 | Pulses one cycle after in_valid |

## Verification
Two functions can fall in the same cycle: the modulo reduction that folds a count back to zero, and the carry update that a nonzero masked count still demands. A plain rotate of a byte by 8 or 16 hits this case, as do carry rotates by 9 or 17. The bench sweeps every count from 0 to 70 for every size and operation, and this covers those cases. A bit-serial model applies the masked and reduced count one bit at a time, and the bench compares the result and both flags against it. Directed cases also combine a count of exactly 1 with an overflow input of the opposite sense, and set junk upper operand bits at each size.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  localparam int DATA_W    = 64;
  localparam int CNT_W     = 8;
  localparam int BASE_W    = 8;
  localparam int NUM_LANES = 4;
  localparam int MC_W      = 6;
  localparam int EN_W      = 7;

  typedef enum logic [1:0] {
    RC_ROTL   = 2'd0,
    RC_ROTR   = 2'd1,
    RC_CARRYL = 2'd2,
    RC_CARRYR = 2'd3
  } rcu_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } rcu_sz_e;

  function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
    return {DATA_W{1'b1}} >> (DATA_W - (BASE_W << sz));
  endfunction

  function automatic logic [MC_W-1:0] masked_count(input logic [1:0] sz,
                                                   input logic [CNT_W-1:0] c);
    return (sz == SZ_D) ? c[MC_W-1:0] : {1'b0, c[MC_W-2:0]};
  endfunction
endpackage

// File: rtl/rcu_count.sv
module rcu_count
  import rcu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [CNT_W-1:0] cnt_raw,
  output logic [MC_W-1:0]  mcnt,
  output logic [EN_W-1:0]  rot_n,
  output logic [EN_W-1:0]  car_n
);
  localparam int MASK_BITS = (W == 64) ? 6 : 5;
  localparam int MC_MAX    = (1 << MASK_BITS) - 1;

  logic [EN_W-1:0] mcnt_ext;

  assign mcnt     = MC_W'(cnt_raw[MASK_BITS-1:0]);
  assign mcnt_ext = EN_W'(mcnt);
  assign rot_n    = mcnt_ext & EN_W'(W - 1);

  generate
    if (MC_MAX >= W + 1) begin : g_fold
      assign car_n = mcnt_ext % EN_W'(W + 1);
    end else begin : g_pass
      assign car_n = mcnt_ext;
    end
  endgenerate
endmodule

// File: rtl/rcu_lane.sv
module rcu_lane
  import rcu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     x,
  input  logic [1:0]       op,
  input  logic [CNT_W-1:0] cnt_raw,
  input  logic             cf_in,
  input  logic             of_in,
  output logic [W-1:0]     y,
  output logic             cf_o,
  output logic             of_o
);
  logic [MC_W-1:0] mcnt;
  logic [EN_W-1:0] rot_n;
  logic [EN_W-1:0] car_n;

  rcu_count #(.W(W)) u_count (
    .cnt_raw (cnt_raw),
    .mcnt    (mcnt),
    .rot_n   (rot_n),
    .car_n   (car_n)
  );

  logic [2*W-1:0] dbl;
  logic [2*W-1:0] dbl_l;
  logic [2*W-1:0] dbl_r;
  logic [W:0]     ext;
  logic [2*W+1:0] edbl;
  logic [2*W+1:0] edbl_l;
  logic [2*W+1:0] edbl_r;
  logic [W-1:0]   rotl_v;
  logic [W-1:0]   rotr_v;
  logic [W:0]     rcl_v;
  logic [W:0]     rcr_v;
  logic           one_cnt;
  logic           nz_cnt;

  assign dbl    = {x, x};
  assign dbl_l  = dbl << rot_n;
  assign dbl_r  = dbl >> rot_n;
  assign rotl_v = dbl_l[2*W-1:W];
  assign rotr_v = dbl_r[W-1:0];

  assign ext    = {cf_in, x};
  assign edbl   = {ext, ext};
  assign edbl_l = edbl << car_n;
  assign edbl_r = edbl >> car_n;
  assign rcl_v  = edbl_l[2*W+1:W+1];
  assign rcr_v  = edbl_r[W:0];

  assign one_cnt = (mcnt == MC_W'(1));
  assign nz_cnt  = (mcnt != '0);

  always_comb begin
    y    = x;
    cf_o = cf_in;
    of_o = of_in;
    case (rcu_op_e'(op))
      RC_ROTL: begin
        y = rotl_v;
        if (nz_cnt)  cf_o = rotl_v[0];
        if (one_cnt) of_o = rotl_v[W-1] ^ rotl_v[0];
      end
      RC_ROTR: begin
        y = rotr_v;
        if (nz_cnt)  cf_o = rotr_v[W-1];
        if (one_cnt) of_o = rotr_v[W-1] ^ rotr_v[W-2];
      end
      RC_CARRYL: begin
        y    = rcl_v[W-1:0];
        cf_o = rcl_v[W];
        if (one_cnt) of_o = rcl_v[W-1] ^ rcl_v[W];
      end
      default: begin
        y    = rcr_v[W-1:0];
        cf_o = rcr_v[W];
        if (one_cnt) of_o = x[W-1] ^ cf_in;
      end
    endcase
  end
endmodule

// File: rtl/rot_carry_unit.sv
module rot_carry_unit
  import rcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  logic              cf_in,
  input  logic              of_in,
  output logic [DATA_W-1:0] result,
  output logic              cf_out,
  output logic              of_out,
  output logic              out_valid
);
  logic [DATA_W-1:0] lane_y  [NUM_LANES];
  logic              lane_cf [NUM_LANES];
  logic              lane_of [NUM_LANES];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LANES; gi++) begin : g_lane
      localparam int LW = BASE_W << gi;
      logic [LW-1:0] y_w;
      rcu_lane #(.W(LW)) u_lane (
        .x       (operand[LW-1:0]),
        .op      (op),
        .cnt_raw (count),
        .cf_in   (cf_in),
        .of_in   (of_in),
        .y       (y_w),
        .cf_o    (lane_cf[gi]),
        .of_o    (lane_of[gi])
      );
      assign lane_y[gi] = DATA_W'(y_w);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      cf_out    <= 1'b0;
      of_out    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= lane_y[size];
        cf_out <= lane_cf[size];
        of_out <= lane_of[size];
      end
    end
  end

  logic [MC_W-1:0]   chk_mcnt;
  logic [DATA_W-1:0] chk_wmask;
  logic [6:0]        chk_msb;
  assign chk_mcnt  = masked_count(size, count);
  assign chk_wmask = width_mask(size);
  assign chk_msb   = 7'((BASE_W << size) - 1);

  AST_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((result & ~$past(chk_wmask)) == '0)); // R9
  AST_OF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && chk_mcnt != MC_W'(1)) |=> (of_out == $past(of_in))); // R8
  AST_ROL_CF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == RC_ROTL && chk_mcnt != '0) |=> (cf_out == result[0])); // R6
  AST_ROR_CF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == RC_ROTR && chk_mcnt != '0) |=> (cf_out == result[$past(chk_msb)])); // R6
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && chk_mcnt == '0) |=> (result == ($past(operand) & $past(chk_wmask)) && cf_out == $past(cf_in))); // R1
  AST_PULSE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(cf_out) && $stable(of_out))); // R10
endmodule

// File: tb/rot_carry_unit_bench.sv
module rot_carry_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [1:0]  size = '0;
  logic [63:0] operand = '0;
  logic [7:0]  count = '0;
  logic        cf_in = 1'b0;
  logic        of_in = 1'b0;
  logic [63:0] result;
  logic        cf_out;
  logic        of_out;
  logic        out_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rot_carry_unit u_rot_carry_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
    .operand(operand), .count(count), .cf_in(cf_in), .of_in(of_in),
    .result(result), .cf_out(cf_out), .of_out(of_out), .out_valid(out_valid)
  );

  logic [63:0] e_res;
  logic        e_cf;
  logic        e_of;

  // Bit-serial model: one single-bit step per unit of effective count.
  task automatic model(input logic [1:0] o, input logic [1:0] s, input logic [63:0] a,
                       input logic [7:0] c, input logic ci, input logic oi);
    int w = 8 << s;
    logic [63:0] wm = {64{1'b1}} >> (64 - w);
    logic [63:0] x = a & wm;
    logic        cf = ci;
    logic        of = oi;
    logic        omsb = x[w-1];
    int m = (w == 64) ? (c & 63) : (c & 31);
    int t;
    if (o >= 2) t = (w == 8) ? m % 9 : (w == 16) ? m % 17 : m;
    else        t = m % w;
    for (int k = 0; k < t; k++) begin
      logic hi = x[w-1];
      logic lo = x[0];
      case (o)
        2'd0: x = ((x << 1) | 64'(hi)) & wm;
        2'd1: x = (x >> 1) | (64'(lo) << (w - 1));
        2'd2: begin x = ((x << 1) | 64'(cf)) & wm; cf = hi; end
        default: begin x = (x >> 1) | (64'(cf) << (w - 1)); cf = lo; end
      endcase
    end
    case (o)
      2'd0: begin if (m != 0) cf = x[0];   if (m == 1) of = x[w-1] ^ cf; end
      2'd1: begin if (m != 0) cf = x[w-1]; if (m == 1) of = x[w-1] ^ x[w-2]; end
      2'd2: begin if (m == 1) of = x[w-1] ^ cf; end
      default: begin if (m == 1) of = omsb ^ ci; end
    endcase
    e_res = x; e_cf = cf; e_of = of;
  endtask

  task automatic apply(input logic [1:0] o, input logic [1:0] s, input logic [63:0] a,
                       input logic [7:0] c, input logic ci, input logic oi);
    @(negedge clk);
    op = o; size = s; operand = a; count = c; cf_in = ci; of_in = oi; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_op(input string tag, input logic [1:0] o, input logic [1:0] s,
                          input logic [63:0] a, input logic [7:0] c, input logic ci, input logic oi);
    apply(o, s, a, c, ci, oi);
    model(o, s, a, c, ci, oi);
    checks++;
    if (result !== e_res || cf_out !== e_cf || of_out !== e_of || out_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s op=%0d sz=%0d cnt=%0d: got res=%h cf=%b of=%b v=%b exp res=%h cf=%b of=%b v=1",
               tag, o, s, c, result, cf_out, of_out, out_valid, e_res, e_cf, e_of);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b exp %b", tag, got, exp);
    end
  endtask

  initial begin
    logic [63:0] pats [3];
    logic [63:0] hold;
    pats[0] = 64'hA5C3_96F0_1E87_4D2B;
    pats[1] = 64'h8000_0000_0000_0001;
    pats[2] = 64'h7FFF_0123_4567_FFFE;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    checks++;
    if (result !== 64'd0 || cf_out !== 1'b0 || of_out !== 1'b0 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: got res=%h cf=%b of=%b v=%b exp all zero", result, cf_out, of_out, out_valid);
    end
    // R1: byte rotate by 32 masks to 0; 64-bit by 64 masks to 0
    check_op("R1", 2'd0, 2'd0, 64'hFF00_0000_0000_00C5, 8'd32, 1'b1, 1'b0);
    check_op("R1", 2'd1, 2'd3, 64'h0123_4567_89AB_CDEF, 8'd64, 1'b0, 1'b1);
    // R5: carry rotates that fold to zero, and unreduced 32-bit
    check_op("R5", 2'd2, 2'd0, 64'h0000_0000_0000_0081, 8'd9, 1'b0, 1'b1);
    check_op("R5", 2'd3, 2'd1, 64'h0000_0000_0000_8001, 8'd17, 1'b1, 1'b0);
    check_op("R5", 2'd2, 2'd2, 64'h0000_0000_8000_0001, 8'd31, 1'b1, 1'b0);
    // R6: plain rotate by width updates carry though distance is zero
    check_op("R6", 2'd0, 2'd0, 64'h0000_0000_0000_0001, 8'd8, 1'b0, 1'b0);
    check_op("R6", 2'd1, 2'd1, 64'h0000_0000_0000_8000, 8'd16, 1'b0, 1'b0);
    // R7: count of one with opposite overflow input
    check_op("R7", 2'd0, 2'd0, 64'h0000_0000_0000_0040, 8'd1, 1'b0, 1'b0);
    check_op("R7", 2'd1, 2'd2, 64'h0000_0000_0000_0001, 8'd1, 1'b0, 1'b0);
    check_op("R7", 2'd2, 2'd1, 64'h0000_0000_0000_4000, 8'd1, 1'b0, 1'b0);
    check_op("R7", 2'd3, 2'd3, 64'h8000_0000_0000_0000, 8'd1, 1'b0, 1'b0);
    // R8: overflow untouched at count 2
    check_op("R8", 2'd3, 2'd0, 64'h0000_0000_0000_0080, 8'd2, 1'b0, 1'b1);
    // R9: junk upper bits ignored, result zero-extended
    check_op("R9", 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FF80, 8'd1, 1'b0, 1'b0);
    check_op("R9", 2'd2, 2'd1, 64'hDEAD_BEEF_CAFE_8000, 8'd3, 1'b1, 1'b0);
    // R10: idle cycle keeps outputs, valid drops
    hold = result;
    @(negedge clk);
    check_bit("R10 valid low when idle", out_valid, 1'b0);
    check_bit("R10 result held when idle", result == hold, 1'b1);
    // Sweep: every op, size, count 0..70, three patterns, both carry values
    for (int o = 0; o < 4; o++) begin
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c <= 70; c++) begin
          for (int p = 0; p < 3; p++) begin
            for (int ci = 0; ci < 2; ci++) begin
              string tg;
              tg = (o == 0 || o == 1) ? "R2" : (o == 2) ? "R3" : "R4";
              check_op(tg, 2'(o), 2'(s), pats[p], 8'(c), 1'(ci), 1'(p & 1));
            end
          end
        end
      end
    end
    // R1: high raw counts beyond 6 bits
    check_op("R1", 2'd2, 2'd3, pats[0], 8'd200, 1'b1, 1'b0);
    check_op("R1", 2'd1, 2'd2, pats[2], 8'd255, 1'b0, 1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule